// File: doc/BRIEF.md
# Performance Counter Access Port

This block holds two banks of event counters, general-purpose and fixed, and gives software a read and a write path into them. The counting itself happens elsewhere; this block only stores the values, writes them, and reads them back through one 32-bit index. In that index, bit 30 chooses the bank and bit 31 asks for a short read. The bank width and the counter count are parameters, each set separately for the two banks. Two constant capability outputs describe the bank sizes to software.

A write keeps the low 32 bits of the data and copies bit 31 into every implemented bit above them. Software can therefore load a negative 32-bit preset and still get a full-width counter that is close to wrapping. A read request moves the read state machine out of `RD_IDLE` for exactly one cycle. If the index names an existing counter, the machine goes to `RD_DATA` and presents the captured value. If the index is out of range, it goes to `RD_FAULT` and presents an error with zero data. From either of those states, the next request again picks `RD_DATA` or `RD_FAULT`, and a cycle with no request returns the machine to `RD_IDLE`. A write to an index that does not exist changes nothing and raises a one-cycle write error.

Top module: `pmc_access_port`

## Requirements
- R1: After reset, every counter reads zero, and `rd_valid`, `rd_err`, `wr_err` and `rd_data` are all zero.
- R2: Index bit 30 = 0 addresses general-purpose counter number `idx[29:0]`, and bit 30 = 1 addresses fixed counter number `idx[29:0]`. The two banks are separate storage.
- R3: A normal read (bit 31 = 0) returns the counter at its bank's implemented width, and all bits above that width are zero.
- R4: A fast read (index bit 31 = 1) returns only the low 32 bits of the counter, with bits 63:32 zero.
- R5: A write stores `wr_data[31:0]` and fills bits 32 up to width-1 with `wr_data[31]`. For example, 0x1_F345_6789 written to a 48-bit counter reads back as 0xFFFF_F345_6789.
- R6: A read of a counter number at or beyond its bank's count gives `rd_err` = 1 with `rd_data` = 0. A write to such an index gives `wr_err` = 1 on the following cycle and changes no counter.
- R7: Read data is registered. `rd_valid` is high on the cycle after `rd_req` and low on the cycle after a cycle without `rd_req`. `rd_data` is zero whenever `rd_valid` is low.
- R8: `cap_word` is {mask length, general-purpose width, general-purpose count, version}, one byte each, with the version in bits 7:0. `cap_fixed` is {fixed width[12:5], fixed count[4:0]}.
- R9: When a read and a write hit the same counter in the same cycle, the read returns the value from before the write, and later reads return the written value.
- R10: Bit 31 of `wr_idx` has no effect on which counter is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read strobe |
| rd_idx | input | 32 | Read index: bit 31 fast, bit 30 bank, bits 29:0 counter number |
| rd_valid | output | 1 | Read response valid, one cycle after `rd_req` |
| rd_err | output | 1 | Read response names no existing counter |
| rd_data | output | 64 | Read response data |
| wr_req | input | 1 | Write strobe |
| wr_idx | input | 32 | Write index: bit 30 bank, bits 29:0 counter number |
| wr_data | input | 64 | Write data; only bits 31:0 are used |
| wr_err | output | 1 | Write named no existing counter, one cycle after `wr_req` |
| cap_word | output | 32 | Capability word for the general-purpose bank |
| cap_fixed | output | 13 | Capability field for the fixed bank |

## Verification
Several kinds of write data are used to separate correct extension from zero-fill and from passing the upper data bits through. Data with bit 31 set tells sign extension apart from zero-fill. Data with bit 31 clear and garbage in bits 63:32 shows that the upper data bits are dropped. Because the two banks have different widths, a fault in the width masking shows up on one bank and not the other. Reads mix both banks, both read kinds and counter numbers on both sides of each bank's count, including very large numbers that would alias if truncated. A read and a write to the same counter in the same cycle expose any bypass of the write into the read. Seeded random operations on all of this are compared against a bench model of the two banks.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_DATA  = 2'd1,
        RD_FAULT = 2'd2
    } rd_state_e;

    localparam int IDX_W     = 32;
    localparam int DATA_W    = 64;
    localparam int LOW_W     = 32;
    localparam int NUM_MSB   = 29;
    localparam int BANK_BIT  = 30;
    localparam int SHORT_BIT = 31;

endpackage

// File: rtl/pmc_idx_decode.sv
module pmc_idx_decode
    import pmc_pkg::*;
#(
    parameter int NUM_GP  = 4,
    parameter int NUM_FIX = 3,
    parameter int SLOT_W  = 2
) (
    input  logic [IDX_W-1:0]  idx,
    output logic              bank_fix,
    output logic              short_rd,
    output logic              gp_hit,
    output logic              fix_hit,
    output logic [SLOT_W-1:0] slot
);

    logic [NUM_MSB:0] number;

    assign number   = idx[NUM_MSB:0];
    assign bank_fix = idx[BANK_BIT];
    assign short_rd = idx[SHORT_BIT];

    // Full-width compare so large numbers never alias onto a real slot
    assign gp_hit  = !idx[BANK_BIT] && (number < (NUM_MSB+1)'(NUM_GP));
    assign fix_hit =  idx[BANK_BIT] && (number < (NUM_MSB+1)'(NUM_FIX));
    assign slot    = number[SLOT_W-1:0];

endmodule

// File: rtl/pmc_ctr_bank.sv
module pmc_ctr_bank
    import pmc_pkg::*;
#(
    parameter int COUNT  = 4,
    parameter int WIDTH  = 48,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [LOW_W-1:0]  wr_low,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_value
);

    logic [WIDTH-1:0] ctr_q [COUNT];
    logic [WIDTH-1:0] ext_val;

    generate
        if (WIDTH > LOW_W) begin : g_sign_fill
            localparam int HI_W = WIDTH - LOW_W;
            assign ext_val = {{HI_W{wr_low[LOW_W-1]}}, wr_low};
        end else begin : g_narrow
            assign ext_val = wr_low[WIDTH-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < COUNT; i++) begin
                ctr_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < COUNT; i++) begin
                if (wr_slot == SLOT_W'(i)) begin
                    ctr_q[i] <= ext_val;
                end
            end
        end
    end

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < COUNT; i++) begin
            if (rd_slot == SLOT_W'(i)) begin
                rd_value[WIDTH-1:0] = ctr_q[i];
            end
        end
    end

endmodule

// File: rtl/pmc_access_port.sv
module pmc_access_port
    import pmc_pkg::*;
#(
    parameter int NUM_GP   = 4,
    parameter int NUM_FIX  = 3,
    parameter int GP_W     = 48,
    parameter int FIX_W    = 40,
    parameter int VERSION  = 2,
    parameter int MASK_LEN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_err,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_req,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    output logic [31:0]       cap_word,
    output logic [12:0]       cap_fixed
);

    localparam int MAX_N  = (NUM_GP > NUM_FIX) ? NUM_GP : NUM_FIX;
    localparam int SLOT_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              wr_err_q;

    logic              rd_bank_fix, rd_short, rd_gp_hit, rd_fix_hit;
    logic [SLOT_W-1:0] rd_slot;
    logic              wr_space_unused, wr_short_unused, wr_gp_hit, wr_fix_hit;
    logic [SLOT_W-1:0] wr_slot;
    logic [DATA_W-1:0] gp_val, fix_val, sel_val, shaped_val;
    logic              rd_hit;
    logic [LOW_W-1:0]  wr_upper_unused;

    assign wr_upper_unused = wr_data[DATA_W-1:LOW_W];

    pmc_idx_decode #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .SLOT_W(SLOT_W)) rd_dec_i (
        .idx      (rd_idx),
        .bank_fix (rd_bank_fix),
        .short_rd (rd_short),
        .gp_hit   (rd_gp_hit),
        .fix_hit  (rd_fix_hit),
        .slot     (rd_slot)
    );

    pmc_idx_decode #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .SLOT_W(SLOT_W)) wr_dec_i (
        .idx      (wr_idx),
        .bank_fix (wr_space_unused),
        .short_rd (wr_short_unused),
        .gp_hit   (wr_gp_hit),
        .fix_hit  (wr_fix_hit),
        .slot     (wr_slot)
    );

    pmc_ctr_bank #(.COUNT(NUM_GP), .WIDTH(GP_W), .SLOT_W(SLOT_W)) gp_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_req && wr_gp_hit),
        .wr_slot  (wr_slot),
        .wr_low   (wr_data[LOW_W-1:0]),
        .rd_slot  (rd_slot),
        .rd_value (gp_val)
    );

    pmc_ctr_bank #(.COUNT(NUM_FIX), .WIDTH(FIX_W), .SLOT_W(SLOT_W)) fix_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_req && wr_fix_hit),
        .wr_slot  (wr_slot),
        .wr_low   (wr_data[LOW_W-1:0]),
        .rd_slot  (rd_slot),
        .rd_value (fix_val)
    );

    assign rd_hit     = rd_gp_hit || rd_fix_hit;
    assign sel_val    = rd_bank_fix ? fix_val : gp_val;
    assign shaped_val = rd_short ? {{(DATA_W-LOW_W){1'b0}}, sel_val[LOW_W-1:0]} : sel_val;

    // Next-state logic
    always_comb begin
        state_d = RD_IDLE;
        if (rd_req) begin
            state_d = rd_hit ? RD_DATA : RD_FAULT;
        end
    end

    // State and captured data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RD_IDLE;
            data_q   <= '0;
            wr_err_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            if (rd_req) begin
                data_q <= rd_hit ? shaped_val : '0;
            end
            wr_err_q <= wr_req && !(wr_gp_hit || wr_fix_hit);
        end
    end

    // Outputs from state
    always_comb begin
        rd_valid = 1'b0;
        rd_err   = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            RD_IDLE: begin
            end
            RD_DATA: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            RD_FAULT: begin
                rd_valid = 1'b1;
                rd_err   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign wr_err    = wr_err_q;
    assign cap_word  = {8'(MASK_LEN), 8'(GP_W), 8'(NUM_GP), 8'(VERSION)};
    assign cap_fixed = {8'(FIX_W), 5'(NUM_FIX)};

endmodule

// File: rtl/pmc_access_port_chk.sv
module pmc_access_port_chk #(
    parameter int NUM_GP  = 4,
    parameter int NUM_FIX = 3,
    parameter int GP_W    = 48,
    parameter int FIX_W   = 40
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req,
    input logic [31:0] rd_idx,
    input logic        rd_valid,
    input logic        rd_err,
    input logic [63:0] rd_data,
    input logic        wr_req,
    input logic [30:0] wr_sel,
    input logic        wr_err
);

    logic rd_oor, wr_oor;
    assign rd_oor = rd_idx[30] ? (rd_idx[29:0] >= 30'(NUM_FIX)) : (rd_idx[29:0] >= 30'(NUM_GP));
    assign wr_oor = wr_sel[30] ? (wr_sel[29:0] >= 30'(NUM_FIX)) : (wr_sel[29:0] >= 30'(NUM_GP));

    assert_valid_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && rd_data == 64'd0));

    assert_err_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_valid && rd_data == 64'd0));

    assert_rd_range_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_oor) |=> rd_err);

    assert_rd_hit_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_oor) |=> !rd_err);

    assert_short_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_idx[31]) |=> (rd_data[63:32] == 32'd0));

    assert_gp_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_idx[30]) |=> ((rd_data >> GP_W) == 64'd0));

    assert_fix_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_idx[30]) |=> ((rd_data >> FIX_W) == 64'd0));

    assert_wr_range_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_oor) |=> wr_err);

    assert_wr_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && wr_oor) |=> !wr_err);

endmodule

bind pmc_access_port pmc_access_port_chk #(
    .NUM_GP  (NUM_GP),
    .NUM_FIX (NUM_FIX),
    .GP_W    (GP_W),
    .FIX_W   (FIX_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_err   (rd_err),
    .rd_data  (rd_data),
    .wr_req   (wr_req),
    .wr_sel   (wr_idx[30:0]),
    .wr_err   (wr_err)
);

// File: tb/pmc_access_port_tb_top.sv
module pmc_access_port_tb_top;

    localparam int NGP  = 4;
    localparam int NFX  = 3;
    localparam int GPW  = 48;
    localparam int FXW  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_idx = '0;
    logic        rd_valid, rd_err, wr_err;
    logic [63:0] rd_data;
    logic        wr_req = 1'b0;
    logic [31:0] wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [31:0] cap_word;
    logic [12:0] cap_fixed;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_gp  [NGP];
    logic [63:0] m_fix [NFX];

    always #5 clk = ~clk;

    pmc_access_port #(.NUM_GP(NGP), .NUM_FIX(NFX), .GP_W(GPW), .FIX_W(FXW),
                      .VERSION(2), .MASK_LEN(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
        .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
        .cap_word(cap_word), .cap_fixed(cap_fixed)
    );

    function automatic logic [63:0] ext_val(input logic [63:0] d, input int w);
        logic [63:0] r;
        r = '0;
        for (int b = 0; b < 64; b++) begin
            if (b < 32) r[b] = d[b];
            else if (b < w) r[b] = d[31];
        end
        return r;
    endfunction

    function automatic logic idx_hit(input logic [31:0] idx);
        return idx[30] ? (idx[29:0] < 30'(NFX)) : (idx[29:0] < 30'(NGP));
    endfunction

    function automatic logic [63:0] rd_expect(input logic [31:0] idx);
        logic [63:0] v;
        if (!idx_hit(idx)) return 64'd0;
        v = idx[30] ? m_fix[idx[1:0]] : m_gp[idx[1:0]];
        if (idx[31]) v = {32'd0, v[31:0]};
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of traffic; results checked at the next falling edge
    task automatic cycle_op(input logic do_rd, input logic [31:0] ridx,
                            input logic do_wr, input logic [31:0] widx,
                            input logic [63:0] wdata, input string req);
        logic [63:0] exp_rd;
        logic        exp_rerr, exp_werr;
        exp_rd   = rd_expect(ridx);
        exp_rerr = !idx_hit(ridx);
        exp_werr = !idx_hit({1'b0, widx[30:0]});
        @(negedge clk);
        rd_req  = do_rd;
        rd_idx  = ridx;
        wr_req  = do_wr;
        wr_idx  = widx;
        wr_data = wdata;
        @(negedge clk);
        rd_req = 1'b0;
        wr_req = 1'b0;
        if (do_rd) begin
            chk({req, " valid"}, 64'(rd_valid), 64'd1);
            chk({req, " err"},   64'(rd_err),   64'(exp_rerr));
            chk({req, " data"},  rd_data,       exp_rd);
        end else begin
            chk({req, " R7 idle valid"}, 64'(rd_valid), 64'd0);
            chk({req, " R7 idle data"},  rd_data,       64'd0);
        end
        chk({req, " wr_err"}, 64'(wr_err), 64'(do_wr && exp_werr));
        if (do_wr && !exp_werr) begin
            if (widx[30]) m_fix[widx[1:0]] = ext_val(wdata, FXW);
            else          m_gp[widx[1:0]]  = ext_val(wdata, GPW);
        end
    endtask

    task automatic rd_only(input logic [31:0] idx, input string req);
        cycle_op(1'b1, idx, 1'b0, 32'd0, 64'd0, req);
    endtask

    task automatic wr_only(input logic [31:0] idx, input logic [63:0] d, input string req);
        cycle_op(1'b0, 32'd0, 1'b1, idx, d, req);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NGP; i++) m_gp[i] = '0;
        for (int i = 0; i < NFX; i++) m_fix[i] = '0;
        void'($urandom(32'd20250611));

        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 rd_err",   64'(rd_err),   64'd0);
        chk("R1 wr_err",   64'(wr_err),   64'd0);
        chk("R1 rd_data",  rd_data,       64'd0);
        rst_n = 1'b1;

        // R1: every counter zero after reset
        for (int i = 0; i < NGP; i++) rd_only(32'(i), "R1 gp");
        for (int i = 0; i < NFX; i++) rd_only(32'h4000_0000 | 32'(i), "R1 fix");

        // R8: capability outputs
        chk("R8 cap_word",  64'(cap_word),  64'({8'd7, 8'd48, 8'd4, 8'd2}));
        chk("R8 cap_fixed", 64'(cap_fixed), 64'({8'd40, 5'd3}));

        // R5: sign fill on 48-bit and 40-bit banks, and dropped upper data
        wr_only(32'd2, 64'h0000_0001_F345_6789, "R5 gp wr");
        rd_only(32'd2, "R5 gp neg");
        chk("R5 literal", m_gp[2], 64'h0000_FFFF_F345_6789);
        wr_only(32'h4000_0001, 64'h0000_0000_8000_0001, "R5 fix wr");
        rd_only(32'h4000_0001, "R5 fix neg");
        chk("R5 fix literal", m_fix[1], 64'h0000_00FF_8000_0001);
        wr_only(32'd3, 64'hDEAD_BEEF_1234_5678, "R5 gp pos wr");
        rd_only(32'd3, "R5 gp pos");

        // R4: fast reads
        rd_only(32'h8000_0002, "R4 gp fast");
        rd_only(32'hC000_0001, "R4 fix fast");

        // R2: separate banks at same number
        wr_only(32'd1, 64'h0000_0000_0000_0AAA, "R2 gp wr");
        wr_only(32'h4000_0001, 64'h0000_0000_0000_0555, "R2 fix wr");
        rd_only(32'd1, "R2 gp");
        rd_only(32'h4000_0001, "R2 fix");

        // R6: out of range reads and writes, storage untouched
        rd_only(32'd4, "R6 gp oor");
        rd_only(32'h4000_0003, "R6 fix oor");
        rd_only(32'h3FFF_FFFF, "R6 gp huge");
        rd_only(32'h4000_0004 | 32'h0100_0000, "R6 fix alias");
        wr_only(32'd5, 64'h0000_0000_7777_7777, "R6 gp wr oor");
        wr_only(32'h4000_0003, 64'h0000_0000_6666_6666, "R6 fix wr oor");
        wr_only(32'h0000_0104, 64'h0000_0000_5555_5555, "R6 gp wr alias");
        for (int i = 0; i < NGP; i++) rd_only(32'(i), "R6 gp intact");
        for (int i = 0; i < NFX; i++) rd_only(32'h4000_0000 | 32'(i), "R6 fix intact");

        // R10: write index bit 31 ignored
        wr_only(32'h8000_0000, 64'h0000_0000_0BAD_CAFE, "R10 wr");
        rd_only(32'd0, "R10 gp0");

        // R9: same-cycle read and write of one counter
        cycle_op(1'b1, 32'd0, 1'b1, 32'd0, 64'h0000_0000_9000_0042, "R9 same");
        rd_only(32'd0, "R9 after");
        cycle_op(1'b1, 32'h4000_0002, 1'b1, 32'h4000_0002, 64'h0000_0000_0000_0077, "R9 fix same");
        rd_only(32'h4000_0002, "R9 fix after");

        // R7: back-to-back reads then an idle cycle
        cycle_op(1'b1, 32'd3, 1'b0, 32'd0, 64'd0, "R7 b2b a");
        cycle_op(1'b1, 32'd5, 1'b0, 32'd0, 64'd0, "R7 b2b b");
        cycle_op(1'b0, 32'd0, 1'b0, 32'd0, 64'd0, "R7 gap");

        // Random mix over all requirements R2 R3 R4 R5 R6 R7 R9 R10
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ri, wi;
            logic [63:0] wd;
            logic        dr, dw;
            dr = ($urandom % 4) != 0;
            dw = ($urandom % 3) == 0;
            ri = {1'($urandom), 1'($urandom), 30'($urandom % 6)};
            wi = {1'($urandom), 1'($urandom), 30'($urandom % 6)};
            if (($urandom % 16) == 0) ri[29:0] = 30'($urandom);
            wd = {$urandom, $urandom};
            cycle_op(dr, ri, dw, wi, wd, "R3 R4 R5 rand");
        end

        summary();
        $finish;
    end

endmodule